// File: doc/BRIEF.md
# Legacy-Capable Interrupt Router

This block turns the interrupt requests of a set of timer channels into a bank of 32 interrupt lines. Each channel presents a request together with its own 5-bit route number, a trigger type and an interrupt enable. A chip-wide enable qualifies every channel. A level-type channel holds its line high for as long as its qualified request stays high. An edge-type channel gives one single-cycle pulse each time its qualified request rises. When several sources share a line, the line is their OR.

Two external inputs also reach fixed lines: a periodic-timer input drives line 0 and a real-time-clock input drives line 8. A legacy-route control changes the mapping. While it is set, channel 0 is forced onto line 0 and channel 1 onto line 8, whatever their route fields hold, and both external inputs are cut off. The block also drives an output that permits or stops the external periodic timer. On entry to and exit from legacy mode it sequences lines 0 and 8 and that output so that no stale level leaks through. Every output is registered, so routing changes take effect one clock after the inputs change.

Top module: `irq_router`

## Requirements
- R1: Outside legacy mode, channel i drives the line numbered by its 5-bit route field, held in bits [5*i+4 : 5*i] of `ch_route`.
- R2: A level-type channel (`ch_level` bit = 1) drives its line high one cycle after its qualified request is seen. The line stays high while the request stays. The line falls on the cycle after the request drops, unless another source still holds it.
- R3: A channel request is qualified only when both its `ch_ie` bit and `glb_en` are 1. An unqualified request has no effect on any line.
- R4: An edge-type channel (`ch_level` bit = 0) produces exactly one single-cycle pulse on its line, one cycle after its qualified request goes from 0 to 1. A request that stays high gives no further pulses.
- R5: With `legacy_mode` = 1, channel 0 drives line 0 and channel 1 drives line 8, and their route fields are ignored. Channels 2 and above keep using their own route field.
- R6: With `legacy_mode` = 0, `ext_tmr_in` drives line 0 one cycle later, as long as `ext_tmr_en` is high. `ext_clk_in` is sampled every cycle, and line 8 follows the sampled level one cycle after that.
- R7: The cycle after `legacy_mode` is seen high, the external inputs no longer drive lines 0 and 8, and `ext_tmr_en` is low.
- R8: The cycle after `legacy_mode` returns to 0, `ext_tmr_en` is high and line 8 shows the last sampled `ext_clk_in` level. For that one cycle `ext_tmr_in` does not drive line 0.
- R9: A line is the OR of all channels routed to it and of any external input routed to it.
- R10: During and after reset, all lines are 0, `ext_tmr_en` is 1 and the sampled clock level is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_en | input | 1 | Chip-wide interrupt enable |
| legacy_mode | input | 1 | Legacy-route control |
| ch_req | input | NUM_CH | Per-channel interrupt request |
| ch_ie | input | NUM_CH | Per-channel interrupt enable |
| ch_level | input | NUM_CH | Trigger type per channel: 1 level, 0 edge |
| ch_route | input | NUM_CH*5 | Packed 5-bit route fields, channel i at [5*i +: 5] |
| ext_tmr_in | input | 1 | External periodic-timer interrupt input |
| ext_clk_in | input | 1 | External real-time-clock interrupt input |
| irq_out | output | 32 | Registered interrupt lines |
| ext_tmr_en | output | 1 | Permit for the external periodic timer |

## Verification
The block holds three kinds of internal state: the per-channel previous-request flag used for edge detection, the registered permit for the external timer, and the sampled clock level. Each one shows at the ports within one or two cycles. A stuck edge flag shows as a missing pulse or a repeated pulse on the channel's line. A wrong permit shows as line 0 following the timer input during the exit cycle from legacy mode. A wrong clock sample shows as a wrong line 8 value on that same exit cycle. The bench compares all 32 lines and the permit against a behavioural model on every clock, so any such fault is reported in the first cycle where it is visible.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   // One-hot vector of a given line number
   function automatic logic [31:0] line_bit(input int unsigned idx);
      logic [31:0] v;
      v = '0;
      v[idx[4:0]] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/irq_chan.sv
module irq_chan
   import irq_router_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int ROUTE_W   = 5,
   parameter int CH_IDX    = 0,
   parameter int LEG_A     = 0,
   parameter int LEG_B     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic                 ie,
   input  logic                 lvl,
   input  logic                 glb_en,
   input  logic                 legacy,
   input  logic [ROUTE_W-1:0]   route,
   output logic [NUM_LINES-1:0] hit
);
   logic qual, qual_q, fire;
   logic [ROUTE_W-1:0] sel;

   assign qual = req & ie & glb_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_q <= 1'b0;
      else        qual_q <= qual;
   end

   assign fire = (trig_e'(lvl) == TRIG_LEVEL) ? qual : (qual & ~qual_q);

   generate
      if (CH_IDX == 0) begin : g_leg_a
         assign sel = legacy ? ROUTE_W'(LEG_A) : route;
      end else if (CH_IDX == 1) begin : g_leg_b
         assign sel = legacy ? ROUTE_W'(LEG_B) : route;
      end else begin : g_plain
         assign sel = route;
      end
   endgenerate

   always_comb begin
      hit = '0;
      if (fire) hit[sel] = 1'b1;
   end
endmodule

// File: rtl/irq_legacy_gate.sv
module irq_legacy_gate #(
   parameter int NUM_LINES = 32,
   parameter int LEG_A     = 0,
   parameter int LEG_B     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 legacy,
   input  logic                 tmr_in,
   input  logic                 rtc_in,
   output logic                 tmr_en,
   output logic [NUM_LINES-1:0] ext_hit
);
   logic rtc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_en <= 1'b1;
         rtc_q  <= 1'b0;
      end else begin
         tmr_en <= ~legacy;
         rtc_q  <= rtc_in;
      end
   end

   always_comb begin
      ext_hit        = '0;
      ext_hit[LEG_A] = tmr_in & tmr_en & ~legacy;
      ext_hit[LEG_B] = rtc_q & ~legacy;
   end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
   parameter int NUM_CH     = 4,
   parameter int NUM_LINES  = 32,
   parameter int LEG_LINE_A = 0,
   parameter int LEG_LINE_B = 8,
   localparam int ROUTE_W   = $clog2(NUM_LINES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      glb_en,
   input  logic                      legacy_mode,
   input  logic [NUM_CH-1:0]         ch_req,
   input  logic [NUM_CH-1:0]         ch_ie,
   input  logic [NUM_CH-1:0]         ch_level,
   input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
   input  logic                      ext_tmr_in,
   input  logic                      ext_clk_in,
   output logic [NUM_LINES-1:0]      irq_out,
   output logic                      ext_tmr_en
);
   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("irq_router: NUM_CH must be at least 2");
      end
      if (NUM_LINES <= LEG_LINE_A || NUM_LINES <= LEG_LINE_B) begin : g_bad_lines
         $error("irq_router: legacy lines must lie inside the line bank");
      end
      if ((1 << ROUTE_W) != NUM_LINES) begin : g_bad_pow2
         $error("irq_router: NUM_LINES must be a power of two");
      end
   endgenerate

   logic [NUM_LINES-1:0] ch_hit [NUM_CH];
   logic [NUM_LINES-1:0] ext_hit;
   logic [NUM_LINES-1:0] next_lines;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      irq_chan #(
         .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W), .CH_IDX(i),
         .LEG_A(LEG_LINE_A), .LEG_B(LEG_LINE_B)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .req    (ch_req[i]),
         .ie     (ch_ie[i]),
         .lvl    (ch_level[i]),
         .glb_en (glb_en),
         .legacy (legacy_mode),
         .route  (ch_route[i*ROUTE_W +: ROUTE_W]),
         .hit    (ch_hit[i])
      );
   end

   irq_legacy_gate #(
      .NUM_LINES(NUM_LINES), .LEG_A(LEG_LINE_A), .LEG_B(LEG_LINE_B)
   ) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .legacy  (legacy_mode),
      .tmr_in  (ext_tmr_in),
      .rtc_in  (ext_clk_in),
      .tmr_en  (ext_tmr_en),
      .ext_hit (ext_hit)
   );

   always_comb begin
      next_lines = ext_hit;
      for (int i = 0; i < NUM_CH; i++) next_lines = next_lines | ch_hit[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= '0;
      else        irq_out <= next_lines;
   end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int NUM_LINES = 32,
   parameter int LEG_A     = 0,
   parameter int LEG_B     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 glb_en,
   input logic                 legacy_mode,
   input logic [NUM_LINES-1:0] irq_out,
   input logic                 ext_tmr_en
);
   logic [NUM_LINES-1:0] ext_mask;
   always_comb begin
      ext_mask        = '0;
      ext_mask[LEG_A] = 1'b1;
      ext_mask[LEG_B] = 1'b1;
   end

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0 && ext_tmr_en)); // R10
   AST_LEGACY_STOPS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_mode |=> !ext_tmr_en); // R7
   AST_NORMAL_PERMITS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_mode |=> ext_tmr_en); // R8
   AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_mode && !glb_en) |=> (irq_out == '0)); // R7
   AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> ((irq_out & ~ext_mask) == '0)); // R3
endmodule

bind irq_router irq_router_chk #(
   .NUM_LINES(NUM_LINES), .LEG_A(LEG_LINE_A), .LEG_B(LEG_LINE_B)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .glb_en      (glb_en),
   .legacy_mode (legacy_mode),
   .irq_out     (irq_out),
   .ext_tmr_en  (ext_tmr_en)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
   localparam int NCH = 4;
   localparam int RW  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic glb_en = 1'b0, legacy_mode = 1'b0, ext_tmr_in = 1'b0, ext_clk_in = 1'b0;
   logic [NCH-1:0] ch_req = '0, ch_ie = '0, ch_level = '0;
   logic [NCH*RW-1:0] ch_route = '0;
   logic [31:0] irq_out;
   logic ext_tmr_en;

   int vectors = 0, miscompares = 0;
   bit done = 1'b0;

   // model state
   logic [31:0] m_lines = '0;
   bit m_en = 1'b1, m_rtc = 1'b0;
   bit m_prev [NCH];

   always #2 clk = ~clk;

   irq_router #(.NUM_CH(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_mode(legacy_mode),
      .ch_req(ch_req), .ch_ie(ch_ie), .ch_level(ch_level), .ch_route(ch_route),
      .ext_tmr_in(ext_tmr_in), .ext_clk_in(ext_clk_in),
      .irq_out(irq_out), .ext_tmr_en(ext_tmr_en)
   );

   task automatic model_tick();
      logic [31:0] nl;
      if (!rst_n) begin
         m_lines = '0; m_en = 1'b1; m_rtc = 1'b0;
         for (int i = 0; i < NCH; i++) m_prev[i] = 1'b0;
         return;
      end
      nl = '0;
      for (int i = 0; i < NCH; i++) begin
         bit q, f;
         int ln;
         q = ch_req[i] && ch_ie[i] && glb_en;
         f = ch_level[i] ? q : (q && !m_prev[i]);
         ln = int'(ch_route[i*RW +: RW]);
         if (legacy_mode && i == 0) ln = 0;
         if (legacy_mode && i == 1) ln = 8;
         if (f) nl[ln] = 1'b1;
         m_prev[i] = q;
      end
      if (!legacy_mode && m_en && ext_tmr_in) nl[0] = 1'b1;
      if (!legacy_mode && m_rtc) nl[8] = 1'b1;
      m_en  = !legacy_mode;
      m_rtc = ext_clk_in;
      m_lines = nl;
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_tick();
      @(negedge clk);
      vectors++;
      if (irq_out !== m_lines || ext_tmr_en !== m_en) begin
         miscompares++;
         $display("FAIL %s: irq_out=%h ext_tmr_en=%b expected irq_out=%h ext_tmr_en=%b",
                  tag, irq_out, ext_tmr_en, m_lines, m_en);
      end
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic set_ch(input int idx, input logic rq, input logic ie,
                         input logic lv, input logic [4:0] rt);
      ch_req[idx] = rq; ch_ie[idx] = ie; ch_level[idx] = lv;
      ch_route[idx*RW +: RW] = rt;
   endtask

   initial begin
      #100000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      step("R10"); step("R10");
      chk("R10 lines", |irq_out, 1'b0);
      chk("R10 tmr_en", ext_tmr_en, 1'b1);
      rst_n = 1'b1;
      step("R10");

      // R1 / R2 level routing
      glb_en = 1'b1;
      set_ch(2, 1, 1, 1, 5'd5);
      step("R1"); chk("R1 line5", irq_out[5], 1'b1);
      set_ch(3, 1, 1, 1, 5'd17);
      step("R1"); chk("R1 line17", irq_out[17], 1'b1);
      step("R2"); chk("R2 held", irq_out[5], 1'b1);
      set_ch(2, 0, 1, 1, 5'd5);
      step("R2"); chk("R2 drop", irq_out[5], 1'b0);

      // R3 qualification
      set_ch(3, 1, 0, 1, 5'd17);
      step("R3"); chk("R3 ie off", irq_out[17], 1'b0);
      set_ch(3, 1, 1, 1, 5'd17); glb_en = 1'b0;
      step("R3"); chk("R3 glb off", irq_out[17], 1'b0);
      glb_en = 1'b1; set_ch(3, 0, 1, 1, 5'd17);
      step("R3");

      // R4 edge pulses
      set_ch(2, 1, 1, 0, 5'd20);
      step("R4"); chk("R4 pulse", irq_out[20], 1'b1);
      step("R4"); chk("R4 single", irq_out[20], 1'b0);
      step("R4"); chk("R4 no repeat", irq_out[20], 1'b0);
      set_ch(2, 0, 1, 0, 5'd20); step("R4");
      set_ch(2, 1, 1, 0, 5'd20);
      step("R4"); chk("R4 repulse", irq_out[20], 1'b1);
      set_ch(2, 0, 1, 0, 5'd20); step("R4");

      // R9 shared line
      set_ch(2, 1, 1, 1, 5'd12); set_ch(3, 1, 1, 1, 5'd12);
      step("R9");
      set_ch(2, 0, 1, 1, 5'd12);
      step("R9"); chk("R9 still held", irq_out[12], 1'b1);
      set_ch(3, 0, 1, 1, 5'd12);
      step("R9"); chk("R9 released", irq_out[12], 1'b0);

      // R6 external inputs
      ext_tmr_in = 1'b1;
      step("R6"); chk("R6 tmr line0", irq_out[0], 1'b1);
      ext_clk_in = 1'b1;
      step("R6"); chk("R6 rtc one sample", irq_out[8], 1'b0);
      step("R6"); chk("R6 rtc line8", irq_out[8], 1'b1);

      // R7 legacy entry
      legacy_mode = 1'b1;
      step("R7"); chk("R7 line0", irq_out[0], 1'b0);
      chk("R7 line8", irq_out[8], 1'b0);
      chk("R7 tmr_en", ext_tmr_en, 1'b0);

      // R5 legacy reroute
      set_ch(0, 1, 1, 1, 5'd3); set_ch(1, 1, 1, 1, 5'd4); set_ch(2, 1, 1, 1, 5'd3);
      step("R5"); chk("R5 ch0 line0", irq_out[0], 1'b1);
      chk("R5 ch1 line8", irq_out[8], 1'b1);
      chk("R5 ch2 own", irq_out[3], 1'b1);
      chk("R5 route4 idle", irq_out[4], 1'b0);
      set_ch(0, 0, 1, 1, 5'd3); set_ch(1, 0, 1, 1, 5'd4); set_ch(2, 0, 1, 1, 5'd3);
      step("R5");

      // R8 legacy exit
      legacy_mode = 1'b0;
      step("R8"); chk("R8 line0 low", irq_out[0], 1'b0);
      chk("R8 line8 restored", irq_out[8], 1'b1);
      chk("R8 tmr_en", ext_tmr_en, 1'b1);
      step("R8"); chk("R8 tmr resumes", irq_out[0], 1'b1);

      // mixed traffic, compared every clock
      for (int n = 0; n < 300; n++) begin
         ch_req = NCH'($urandom); ch_ie = NCH'($urandom | 32'h5);
         ch_level = NCH'($urandom);
         ch_route = (NCH*RW)'($urandom);
         glb_en = ($urandom % 5) != 0;
         legacy_mode = ($urandom % 6) == 0;
         ext_tmr_in = 1'($urandom); ext_clk_in = 1'($urandom);
         step("R9");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule